// File: doc/BRIEF.md
# Scalar Vector-Move Instruction Decoder

This block is purely combinational. It decodes the two-opcode family that copies a 32-bit or 64-bit scalar between a general register or a memory location and the low part of a vector register. Prefix scanning is already done upstream, so the block sees parsed prefix facts: the 66h operand-size prefix, the REX bits, and the VEX fields (presence, map, implied prefix, length, W, vvvv). It also sees the opcode byte, the ModRM byte and a flag that marks 64-bit mode.

From these it produces one decision. This covers whether the instruction belongs to the family, which way the data moves, the scalar width, and whether the vector side is an MMX or an XMM register. It also says whether the form was VEX-encoded, gives the vector and general/memory operand indices, and reports whether the r/m side is memory.

VEX forms with an illegal length, a non-idle vvvv field, or a 64-bit width outside 64-bit mode raise an invalid-opcode fault. The extension bits rex_r and rex_b are supplied in true (non-inverted) polarity by the prefix parser, whether they came from a REX or a VEX prefix.

Top module: `vmov_decoder`

## Requirements
- R1: Opcode 8'h6E sets dec_to_vec to 1 (data moves into the vector register named by ModRM reg); opcode 8'h7E sets dec_to_vec to 0 (data moves out of it to the r/m operand).
- R2: A legacy (non-VEX) form selects an XMM vector register (dec_xmm=1) when opsize_pfx is 1, and an MMX register (dec_xmm=0) otherwise.
- R3: A legacy form is 64 bits wide (dec_wide=1) only when long_mode, rex_present and rex_w are all 1. Outside 64-bit mode the REX inputs have no effect on width or on either index.
- R4: A VEX form belongs to the family only when vex_map is 5'd1 and vex_pp is 2'b01. It then reports dec_vex=1 and dec_xmm=1. Any other map or pp value gives all outputs 0.
- R5: A VEX form in the family is 64 bits wide when vex_w is 1 and 32 bits wide when vex_w is 0.
- R6: A VEX form in the family raises dec_fault and clears dec_valid when vex_l is 1, or vex_vvvv is not 4'hF, or vex_w is 1 while long_mode is 0. Otherwise dec_valid is 1 and dec_fault is 0.
- R7: dec_reg_idx names the vector register. For XMM it is {long_mode & rex_r, modrm[5:3]}. For MMX it is {1'b0, modrm[5:3]}.
- R8: dec_rm_idx is {long_mode & rex_b, modrm[2:0]}. dec_mem is 1 exactly when modrm[7:6] is not 2'b11.
- R9: Any opcode other than 8'h6E or 8'h7E gives dec_valid=0, dec_fault=0 and every other output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| long_mode | input | 1 | Processor is in 64-bit mode |
| opsize_pfx | input | 1 | 66h operand-size prefix present |
| rex_present | input | 1 | A REX prefix was seen |
| rex_w | input | 1 | REX width bit |
| rex_r | input | 1 | Register-field extension bit, true polarity |
| rex_b | input | 1 | r/m-field extension bit, true polarity |
| vex_present | input | 1 | Instruction uses VEX encoding |
| vex_map | input | 5 | VEX opcode map select (1 = 0F map) |
| vex_pp | input | 2 | VEX implied prefix (01 = 66h) |
| vex_l | input | 1 | VEX vector length bit |
| vex_w | input | 1 | VEX width bit |
| vex_vvvv | input | 4 | VEX extra register field as encoded |
| opcode | input | 8 | Opcode byte after the escape |
| modrm | input | 8 | ModRM byte |
| dec_valid | output | 1 | Legal member of the family |
| dec_fault | output | 1 | Invalid-opcode fault |
| dec_to_vec | output | 1 | 1 = into vector register, 0 = out of it |
| dec_wide | output | 1 | 1 = 64-bit scalar, 0 = 32-bit |
| dec_xmm | output | 1 | 1 = XMM, 0 = MMX |
| dec_vex | output | 1 | VEX-encoded form |
| dec_mem | output | 1 | r/m operand is memory |
| dec_reg_idx | output | 4 | Vector register index |
| dec_rm_idx | output | 4 | General register or base index from r/m |

## Verification
The in-line checks assume that the inputs are known, settled two-state values whenever they are evaluated, and that exactly one prefix style describes the instruction. The REX bits are treated as meaningful only for legacy forms, and the VEX fields only when vex_present is set. The bench holds each input pattern for a whole clock period and compares the outputs at the opposite edge. Each pattern sets a consistent prefix picture, and REX bits are applied on purpose outside 64-bit mode to show that they are ignored there.

// File: rtl/vmov_pkg.sv
package vmov_pkg;
  localparam int FIELD_W = 3;
  localparam int IDX_W   = FIELD_W + 1;

  typedef struct packed {
    logic valid;
    logic fault;
    logic to_vec;
    logic wide;
    logic xmm;
    logic vex;
  } form_t;

  // Join an extension bit with a 3-bit ModRM field.
  function automatic logic [IDX_W-1:0] join_index(input logic ext, input logic [FIELD_W-1:0] field);
    return {ext, field};
  endfunction

  // Legacy width: promotion to 64 bits exists only in 64-bit mode.
  function automatic logic legacy_wide(input logic lm, input logic rp, input logic rw);
    return lm & rp & rw;
  endfunction

  // VEX fault conditions for this family.
  function automatic logic vex_illegal(input logic lm, input logic l, input logic w,
                                       input logic [3:0] vvvv);
    return l | (vvvv != 4'hF) | (w & ~lm);
  endfunction
endpackage

// File: rtl/vmov_form_decode.sv
module vmov_form_decode
  import vmov_pkg::*;
#(
  parameter logic [7:0] OPC_TO_VEC   = 8'h6E,
  parameter logic [7:0] OPC_FROM_VEC = 8'h7E,
  parameter logic [4:0] VEX_MAP_SEL  = 5'd1,
  parameter logic [1:0] VEX_PP_SEL   = 2'b01
) (
  input  logic       long_mode,
  input  logic       opsize_pfx,
  input  logic       rex_present,
  input  logic       rex_w,
  input  logic       vex_present,
  input  logic [4:0] vex_map,
  input  logic [1:0] vex_pp,
  input  logic       vex_l,
  input  logic       vex_w,
  input  logic [3:0] vex_vvvv,
  input  logic [7:0] opcode,
  output form_t      form
);
  logic opc_to_vec, opc_from_vec, in_family;
  logic legacy_hit, vex_shape_ok, vex_hit, vex_bad;

  always_comb begin
    opc_to_vec   = (opcode == OPC_TO_VEC);
    opc_from_vec = (opcode == OPC_FROM_VEC);
    in_family    = opc_to_vec | opc_from_vec;
    legacy_hit   = in_family & ~vex_present;
    vex_shape_ok = (vex_map == VEX_MAP_SEL) && (vex_pp == VEX_PP_SEL);
    vex_hit      = in_family & vex_present & vex_shape_ok;
    vex_bad      = vex_illegal(long_mode, vex_l, vex_w, vex_vvvv);
  end

  always_comb begin
    form = '0;
    if (legacy_hit) begin
      form.valid  = 1'b1;
      form.to_vec = opc_to_vec;
      form.xmm    = opsize_pfx;
      form.wide   = legacy_wide(long_mode, rex_present, rex_w);
    end else if (vex_hit) begin
      form.valid  = ~vex_bad;
      form.fault  = vex_bad;
      form.to_vec = opc_to_vec;
      form.xmm    = 1'b1;
      form.vex    = 1'b1;
      form.wide   = vex_w;
    end
  end

  always_comb begin
    assert_fault_blocks_valid_R6: assert (!(form.fault && form.valid));
    assert_wide_needs_long_R3: assert (!(form.valid && form.wide) || long_mode);
    assert_idle_quiet_R9: assert (in_family || (!form.valid && !form.fault));
    assert_vex_is_xmm_R4: assert (!form.vex || form.xmm);
    assert_direction_follows_opcode_R1: assert (!form.valid || (form.to_vec == (opcode == OPC_TO_VEC)));
  end
endmodule

// File: rtl/vmov_operand_decode.sv
module vmov_operand_decode
  import vmov_pkg::*;
#(
  parameter logic [1:0] MOD_REG = 2'b11
) (
  input  logic             hit,
  input  logic             long_mode,
  input  logic             xmm,
  input  logic             rex_r,
  input  logic             rex_b,
  input  logic [7:0]       modrm,
  output logic [IDX_W-1:0] reg_idx,
  output logic [IDX_W-1:0] rm_idx,
  output logic             mem
);
  logic [1:0]         mod_f;
  logic [FIELD_W-1:0] reg_f, rm_f;
  logic               ext_r, ext_b;

  always_comb begin
    mod_f = modrm[7:6];
    reg_f = modrm[5:3];
    rm_f  = modrm[2:0];
    // Extension bits exist only in 64-bit mode; MMX has eight registers.
    ext_r = long_mode & rex_r & xmm;
    ext_b = long_mode & rex_b;
    reg_idx = '0;
    rm_idx  = '0;
    mem     = 1'b0;
    if (hit) begin
      reg_idx = join_index(ext_r, reg_f);
      rm_idx  = join_index(ext_b, rm_f);
      mem     = (mod_f != MOD_REG);
    end
  end

  always_comb begin
    assert_mmx_index_narrow_R7: assert (!(hit && !xmm && reg_idx[IDX_W-1]));
    assert_no_ext_outside_long_R3: assert (long_mode || (!reg_idx[IDX_W-1] && !rm_idx[IDX_W-1]));
  end
endmodule

// File: rtl/vmov_decoder.sv
module vmov_decoder
  import vmov_pkg::*;
(
  input  logic       long_mode,
  input  logic       opsize_pfx,
  input  logic       rex_present,
  input  logic       rex_w,
  input  logic       rex_r,
  input  logic       rex_b,
  input  logic       vex_present,
  input  logic [4:0] vex_map,
  input  logic [1:0] vex_pp,
  input  logic       vex_l,
  input  logic       vex_w,
  input  logic [3:0] vex_vvvv,
  input  logic [7:0] opcode,
  input  logic [7:0] modrm,
  output logic       dec_valid,
  output logic       dec_fault,
  output logic       dec_to_vec,
  output logic       dec_wide,
  output logic       dec_xmm,
  output logic       dec_vex,
  output logic       dec_mem,
  output logic [3:0] dec_reg_idx,
  output logic [3:0] dec_rm_idx
);
  form_t form;
  logic  family_hit;

  vmov_form_decode u_form (
    .long_mode  (long_mode),
    .opsize_pfx (opsize_pfx),
    .rex_present(rex_present),
    .rex_w      (rex_w),
    .vex_present(vex_present),
    .vex_map    (vex_map),
    .vex_pp     (vex_pp),
    .vex_l      (vex_l),
    .vex_w      (vex_w),
    .vex_vvvv   (vex_vvvv),
    .opcode     (opcode),
    .form       (form)
  );

  assign family_hit = form.valid | form.fault;

  vmov_operand_decode u_opnd (
    .hit      (family_hit),
    .long_mode(long_mode),
    .xmm      (form.xmm),
    .rex_r    (rex_r),
    .rex_b    (rex_b),
    .modrm    (modrm),
    .reg_idx  (dec_reg_idx),
    .rm_idx   (dec_rm_idx),
    .mem      (dec_mem)
  );

  assign dec_valid  = form.valid;
  assign dec_fault  = form.fault;
  assign dec_to_vec = form.to_vec;
  assign dec_wide   = form.wide;
  assign dec_xmm    = form.xmm;
  assign dec_vex    = form.vex;

  always_comb begin
    assert_reg_operand_no_mem_R8: assert (!(modrm[7:6] == 2'b11 && dec_mem));
    assert_vex_width_R5: assert (!(dec_valid && dec_vex) || (dec_wide == vex_w));
  end
endmodule

// File: tb/vmov_decoder_bench.sv
module vmov_decoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       long_mode, opsize_pfx, rex_present, rex_w, rex_r, rex_b;
  logic       vex_present, vex_l, vex_w;
  logic [4:0] vex_map;
  logic [1:0] vex_pp;
  logic [3:0] vex_vvvv;
  logic [7:0] opcode, modrm;
  logic       dec_valid, dec_fault, dec_to_vec, dec_wide, dec_xmm, dec_vex, dec_mem;
  logic [3:0] dec_reg_idx, dec_rm_idx;

  vmov_decoder u_vmov_decoder (
    .long_mode(long_mode), .opsize_pfx(opsize_pfx), .rex_present(rex_present),
    .rex_w(rex_w), .rex_r(rex_r), .rex_b(rex_b), .vex_present(vex_present),
    .vex_map(vex_map), .vex_pp(vex_pp), .vex_l(vex_l), .vex_w(vex_w),
    .vex_vvvv(vex_vvvv), .opcode(opcode), .modrm(modrm),
    .dec_valid(dec_valid), .dec_fault(dec_fault), .dec_to_vec(dec_to_vec),
    .dec_wide(dec_wide), .dec_xmm(dec_xmm), .dec_vex(dec_vex), .dec_mem(dec_mem),
    .dec_reg_idx(dec_reg_idx), .dec_rm_idx(dec_rm_idx)
  );

  typedef struct {
    logic [14:0] want;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Expected outputs, bit order {valid,fault,to_vec,wide,xmm,vex,mem,reg[3:0],rm[3:0]}
  function automatic logic [14:0] model(
    input logic lm, input logic o66, input logic rp, input logic rw, input logic rr,
    input logic rb, input logic vp, input logic [4:0] mp, input logic [1:0] pp,
    input logic l, input logic w, input logic [3:0] vv, input logic [7:0] opc,
    input logic [7:0] mrm);
    logic v, f, tv, wd, x, vx, m;
    logic [3:0] ri, bi;
    if (opc != 8'h6E && opc != 8'h7E) return 15'd0;
    tv = (opc == 8'h6E);
    if (vp) begin
      if (mp != 5'd1 || pp != 2'b01) return 15'd0;
      x = 1'b1; vx = 1'b1; wd = w;
      f = (l == 1'b1) || (vv != 4'b1111) || (w && !lm);
      v = !f;
    end else begin
      x = o66; vx = 1'b0; f = 1'b0; v = 1'b1;
      wd = lm ? (rp && rw) : 1'b0;
    end
    m  = (mrm[7:6] != 2'b11);
    ri = {(x && lm && rr), mrm[5:3]};
    bi = {(lm && rb), mrm[2:0]};
    return {v, f, tv, wd, x, vx, m, ri, bi};
  endfunction

  task automatic drive(
    input logic lm, input logic o66, input logic rp, input logic rw, input logic rr,
    input logic rb, input logic vp, input logic [4:0] mp, input logic [1:0] pp,
    input logic l, input logic w, input logic [3:0] vv, input logic [7:0] opc,
    input logic [7:0] mrm, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    long_mode = lm; opsize_pfx = o66; rex_present = rp; rex_w = rw; rex_r = rr;
    rex_b = rb; vex_present = vp; vex_map = mp; vex_pp = pp; vex_l = l; vex_w = w;
    vex_vvvv = vv; opcode = opc; modrm = mrm;
    it.want = model(lm, o66, rp, rw, rr, rb, vp, mp, pp, l, w, vv, opc, mrm);
    it.tag  = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: compare at the falling edge, away from the driving edge.
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      item_t it;
      logic [14:0] got;
      it  = exp_q.pop_front();
      got = {dec_valid, dec_fault, dec_to_vec, dec_wide, dec_xmm, dec_vex, dec_mem,
             dec_reg_idx, dec_rm_idx};
      checks++;
      if (got !== it.want) begin
        errors++;
        $display("FAIL %s: got %015b expected %015b", it.tag, got, it.want);
      end
    end
  end

  initial begin
    long_mode = 0; opsize_pfx = 0; rex_present = 0; rex_w = 0; rex_r = 0; rex_b = 0;
    vex_present = 0; vex_map = 0; vex_pp = 0; vex_l = 0; vex_w = 0; vex_vvvv = 0;
    opcode = 0; modrm = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R9 idle state after reset: all zero
    drive(0,0,0,0,0,0, 0,5'd0,2'b00,0,0,4'h0, 8'h00,8'h00, "R9 idle");
    // R1 R2 legacy MMX, into vector
    drive(1,0,0,0,0,0, 0,5'd0,2'b00,0,0,4'h0, 8'h6E,8'hC1, "R1 R2 mmx in");
    // R1 R2 legacy XMM, out of vector
    drive(1,1,0,0,0,0, 0,5'd0,2'b00,0,0,4'h0, 8'h7E,8'hDA, "R1 R2 xmm out");
    // R3 promotion in 64-bit mode
    drive(1,1,1,1,0,0, 0,5'd0,2'b00,0,0,4'h0, 8'h6E,8'hC8, "R3 wide");
    // R3 REX ignored outside 64-bit mode
    drive(0,1,1,1,1,1, 0,5'd0,2'b00,0,0,4'h0, 8'h6E,8'hFF, "R3 rex ignored");
    // R7 R8 extension bits for XMM
    drive(1,1,1,0,1,1, 0,5'd0,2'b00,0,0,4'h0, 8'h7E,8'hD3, "R7 R8 ext xmm");
    // R7 no register extension for MMX
    drive(1,0,1,0,1,1, 0,5'd0,2'b00,0,0,4'h0, 8'h7E,8'hED, "R7 mmx narrow");
    // R8 memory operand
    drive(1,1,0,0,0,0, 0,5'd0,2'b00,0,0,4'h0, 8'h6E,8'h45, "R8 mem");
    // R4 R5 VEX 32-bit
    drive(1,0,0,0,0,0, 1,5'd1,2'b01,0,0,4'hF, 8'h6E,8'hC2, "R4 R5 vex w0");
    // R5 VEX 64-bit
    drive(1,0,0,0,1,0, 1,5'd1,2'b01,0,1,4'hF, 8'h7E,8'hCB, "R5 vex w1");
    // R6 faults
    drive(1,0,0,0,0,0, 1,5'd1,2'b01,1,0,4'hF, 8'h6E,8'hC0, "R6 vex L");
    drive(1,0,0,0,0,0, 1,5'd1,2'b01,0,0,4'h7, 8'h7E,8'h04, "R6 vex vvvv");
    drive(0,0,0,0,0,0, 1,5'd1,2'b01,0,1,4'hF, 8'h6E,8'hC3, "R6 vex w1 legacy mode");
    drive(0,0,0,0,0,0, 1,5'd1,2'b01,0,0,4'hF, 8'h6E,8'hC3, "R6 vex w0 legacy mode ok");
    // R4 shape mismatch
    drive(1,0,0,0,0,0, 1,5'd1,2'b00,0,0,4'hF, 8'h6E,8'hC1, "R4 vex pp");
    drive(1,0,0,0,0,0, 1,5'd2,2'b01,0,0,4'hF, 8'h7E,8'hC1, "R4 vex map");
    // R9 other opcode with prefixes present
    drive(1,1,1,1,1,1, 0,5'd0,2'b00,0,0,4'h0, 8'h6F,8'h12, "R9 other opcode");
    drive(1,0,0,0,0,0, 1,5'd1,2'b01,1,1,4'h0, 8'h7F,8'h12, "R9 other opcode vex");
    // R8 sweep of every ModRM value
    for (int i = 0; i < 256; i++)
      drive(1,1,1,0,i[0],i[1], 0,5'd0,2'b00,0,0,4'h0, 8'h7E,i[7:0], "R8 sweep");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule